// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator with Dead Time

This block drives the six switches of a three-phase inverter bridge. Each phase has a positive output and a negative output. A triangle carrier is built from two up/down counters that step together. The lower counter sweeps from zero up to the half-period and back. The upper counter runs the same sweep shifted up by the effective dead time.

Each phase compares its active duty value against both counters. The positive output is active while the lower counter is at or above the duty value. The negative output is active while the upper counter is below the duty value. Because the two counters differ by the dead time, both outputs are inactive for a dead-time gap around every switching point.

Duty values enter through the duty input. They reach the active compare registers only at the carrier peak, so a PWM period never uses a partly updated duty. An optional second buffer stage can be enabled; it captures new values at the valley. The block also provides per-pin output enables, a separate active level for the positive side and for the negative side, and an optional output that toggles once every PWM period. Configuration is changed only while counting is stopped.

Top module: `cpwm_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every PWM output sits at its inactive level (the inverse of its polarity select) and the toggle output is 0.
- R2: While `run` is 0, the lower counter is loaded with 0 and the upper counter is loaded with the effective dead time d, both set to count upward. While `run` is 1, both counters change by one on every clock: the lower counter runs 0,1,...,H,H-1,...,1,0,1,... and the upper counter runs d above it. This gives a carrier period of 2H clocks, where H is `half_period` (H >= 2).
- R3: The effective dead time d equals `dead_time` when `dt_en` is 1, and equals 1 when `dt_en` is 0.
- R4: For a phase with active duty D where 0 < D < H, the positive side is active while the lower counter is >= D.
- R5: For the same range of D, the negative side is active while the upper counter is < D. This leaves both sides inactive for d counts before and after each positive-side interval.
- R6: A duty of 0 makes the positive side active for the whole period and the negative side never active. A duty >= H makes the negative side active for the whole period and the positive side never active.
- R7: The positive and negative outputs of a phase are never active together, including on the cycle in which a new duty takes effect.
- R8: With `dbuf_en` = 0, the active duty of each phase is loaded from `duty_in` on the clock edge at which the lower counter equals H, and at no other edge while running. While stopped, it is loaded on every edge.
- R9: With `dbuf_en` = 1, a second stage captures `duty_in` on the edge at which the lower counter is 0 while running. The active duty is loaded from that stage at the peak edge. While stopped, both are loaded from `duty_in`.
- R10: `pol_p` = 1 makes the positive outputs active-high and `pol_p` = 0 makes them active-low. `pol_n` sets the negative outputs in the same way, independently of `pol_p`.
- R11: `out_en` bit i (for i < 3) enables `pwm_p[i]`, and bit 3+i enables `pwm_n[i]`. A disabled output holds its inactive level.
- R12: With `tog_en` = 1 and `run` = 1, `tog_out` inverts on every edge at which the lower counter is 0, which is once per PWM period. Otherwise it holds its value.
- R13: The outputs are registered. After the k-th running edge, each output reflects the counters as they stood before that edge. While stopped, all PWM outputs are at their inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Count enable for both counters |
| half_period | input | CW | Carrier half-period H |
| dead_time | input | CW | Dead time in clocks |
| dt_en | input | 1 | Dead-time enable (0 forces d = 1) |
| duty_in | input | NPH*CW | Duty values, phase i in bits [i*CW +: CW] |
| dbuf_en | input | 1 | Enable the second buffer stage |
| pol_p | input | 1 | Active level of the positive outputs |
| pol_n | input | 1 | Active level of the negative outputs |
| out_en | input | 2*NPH | Per-pin enables: positive pins low, negative pins high |
| tog_en | input | 1 | Enable the per-period toggle output |
| pwm_p | output | NPH | Positive-side outputs |
| pwm_n | output | NPH | Negative-side outputs |
| tog_out | output | 1 | Output that toggles once per period |

## Verification
The compare path is swept with every duty value from 0 to H+1 on each phase, with the phases offset so they differ from one another. This separates the constant-output cases (0 and >= H) from the normal dead-time window and exposes an off-by-one at either end. Runs with dead time 1, 2 and 3, with `dt_en` low, and with an odd half-period show whether the counter offset and the carrier shape follow the configuration. Duty changes written in mid-period, with each buffer mode, show whether a transfer happens at the wrong edge. The polarity and enable patterns test each pin's active level and its masking separately.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} dir_e;
endpackage

// File: rtl/cpwm_counter.sv
module cpwm_counter
  import cpwm_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] lo,
  input  logic [CW-1:0] hi,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] ONE = 1;

  dir_e dir;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= lo;
      dir <= DIR_UP;
    end else if (dir == DIR_UP) begin
      if (cnt == hi) begin
        cnt <= cnt - ONE;
        dir <= DIR_DN;
      end else begin
        cnt <= cnt + ONE;
      end
    end else begin
      if (cnt == lo) begin
        cnt <= cnt + ONE;
        dir <= DIR_UP;
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end

  // R2: the counter stays within its limits while the limits are steady
  p_range_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && $stable(lo) && $stable(hi)) |-> (cnt >= lo && cnt <= hi));
endmodule

// File: rtl/cpwm_phase.sv
module cpwm_phase #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          peak,
  input  logic          valley,
  input  logic          dbuf_en,
  input  logic [CW-1:0] duty_in,
  input  logic [CW-1:0] half,
  input  logic [CW-1:0] cnt_lo,
  input  logic [CW-1:0] cnt_hi,
  input  logic          pol_p,
  input  logic          pol_n,
  input  logic          en_p,
  input  logic          en_n,
  output logic          pin_p,
  output logic          pin_n
);
  logic [CW-1:0] stage_q;
  logic [CW-1:0] act_q;
  logic          full_n;
  logic          p_act;
  logic          n_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      act_q   <= '0;
    end else if (!run) begin
      stage_q <= duty_in;
      act_q   <= duty_in;
    end else begin
      if (valley) stage_q <= duty_in;
      if (peak)   act_q   <= dbuf_en ? stage_q : duty_in;
    end
  end

  always_comb begin
    full_n = (act_q >= half);
    p_act  = !full_n && (cnt_lo >= act_q);
    n_act  = full_n || (cnt_hi < act_q);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pin_p <= ~pol_p;
      pin_n <= ~pol_n;
    end else begin
      pin_p <= (en_p && p_act) ? pol_p : ~pol_p;
      pin_n <= (en_n && n_act) ? pol_n : ~pol_n;
    end
  end

  // R7: the two sides of a phase are never active together
  p_no_overlap_r7: assert property (@(posedge clk) disable iff (rst)
    ($stable(pol_p) && $stable(pol_n)) |-> !((pin_p == pol_p) && (pin_n == pol_n)));

  // R8: while running, the active duty changes only at the peak
  p_duty_hold_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && !$past(peak)) |-> $stable(act_q));

  // R9: while running, the second stage changes only at the valley
  p_stage_hold_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && !$past(valley)) |-> $stable(stage_q));

  // R11: a disabled pin sits at its inactive level
  p_disabled_r11: assert property (@(posedge clk) disable iff (rst)
    ($past(!en_p) && $stable(pol_p)) |-> (pin_p != pol_p));
endmodule

// File: rtl/cpwm_top.sv
module cpwm_top #(
  parameter int CW  = 8,
  parameter int NPH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [CW-1:0]     half_period,
  input  logic [CW-1:0]     dead_time,
  input  logic              dt_en,
  input  logic [NPH*CW-1:0] duty_in,
  input  logic              dbuf_en,
  input  logic              pol_p,
  input  logic              pol_n,
  input  logic [2*NPH-1:0]  out_en,
  input  logic              tog_en,
  output logic [NPH-1:0]    pwm_p,
  output logic [NPH-1:0]    pwm_n,
  output logic              tog_out
);
  localparam logic [CW-1:0] ONE = 1;

  logic [CW-1:0] d_eff;
  logic [CW-1:0] top_hi;
  logic [CW-1:0] t_lo;
  logic [CW-1:0] t_hi;
  logic          peak;
  logic          valley;

  always_comb begin
    d_eff  = dt_en ? dead_time : ONE;
    top_hi = half_period + d_eff;
    peak   = run && (t_lo == half_period);
    valley = run && (t_lo == '0);
  end

  cpwm_counter #(.CW(CW)) u_cnt_lo (
    .clk(clk), .rst(rst), .run(run),
    .lo('0), .hi(half_period), .cnt(t_lo)
  );

  cpwm_counter #(.CW(CW)) u_cnt_hi (
    .clk(clk), .rst(rst), .run(run),
    .lo(d_eff), .hi(top_hi), .cnt(t_hi)
  );

  always_ff @(posedge clk) begin
    if (rst)                   tog_out <= 1'b0;
    else if (valley && tog_en) tog_out <= ~tog_out;
  end

  for (genvar i = 0; i < NPH; i++) begin : g_phase
    cpwm_phase #(.CW(CW)) u_phase (
      .clk(clk), .rst(rst), .run(run),
      .peak(peak), .valley(valley), .dbuf_en(dbuf_en),
      .duty_in(duty_in[i*CW +: CW]), .half(half_period),
      .cnt_lo(t_lo), .cnt_hi(t_hi),
      .pol_p(pol_p), .pol_n(pol_n),
      .en_p(out_en[i]), .en_n(out_en[NPH+i]),
      .pin_p(pwm_p[i]), .pin_n(pwm_n[i])
    );
  end

  // R3: the upper counter stays exactly d above the lower one
  p_offset_r3: assert property (@(posedge clk) disable iff (rst)
    $past(run) |-> (t_hi == CW'(t_lo + d_eff)));

  // R12: the toggle output moves only on a valley edge
  p_tog_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !$past(valley) |-> $stable(tog_out));
endmodule

// File: tb/cpwm_top_tb.sv
`timescale 1ns/1ps
module cpwm_top_tb;
  localparam int CW = 8;
  localparam int NPH = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic [CW-1:0] half_period = 8'd6;
  logic [CW-1:0] dead_time = 8'd2;
  logic dt_en = 1'b1;
  logic [CW-1:0] duty_b [NPH];
  logic dbuf_en = 1'b0;
  logic pol_p = 1'b1;
  logic pol_n = 1'b1;
  logic [2*NPH-1:0] out_en = '1;
  logic tog_en = 1'b1;
  logic [NPH-1:0] pwm_p, pwm_n;
  logic tog_out;
  logic [NPH*CW-1:0] duty_in;

  assign duty_in = {duty_b[2], duty_b[1], duty_b[0]};

  always #4 clk = ~clk;

  cpwm_top #(.CW(CW), .NPH(NPH)) u_dut (
    .clk(clk), .rst(rst), .run(run), .half_period(half_period),
    .dead_time(dead_time), .dt_en(dt_en), .duty_in(duty_in),
    .dbuf_en(dbuf_en), .pol_p(pol_p), .pol_n(pol_n), .out_en(out_en),
    .tog_en(tog_en), .pwm_p(pwm_p), .pwm_n(pwm_n), .tog_out(tog_out)
  );

  int n_tests = 0;
  int n_fail = 0;
  int k = 0;
  int act_m [NPH];
  int stg_m [NPH];
  logic tog_m = 1'b0;

  task automatic chk(input logic ok, input string tag, input int actv, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actv, expv);
    end
  endtask

  function automatic int tri_at(input int kk, input int h);
    int m = kk % (2*h);
    return (m <= h) ? m : 2*h - m;
  endfunction

  task automatic step(input string tag);
    logic [NPH-1:0] ep, en;
    int h = int'(half_period);
    int d = dt_en ? int'(dead_time) : 1;
    @(posedge clk);
    if (!run) begin
      for (int i = 0; i < NPH; i++) begin
        act_m[i] = int'(duty_b[i]);
        stg_m[i] = int'(duty_b[i]);
        ep[i] = ~pol_p;
        en[i] = ~pol_n;
      end
      k = 0;
    end else begin
      int t = tri_at(k, h);
      int a = t + d;
      for (int i = 0; i < NPH; i++) begin
        int dv = act_m[i];
        logic pa = (dv < h) && (t >= dv);
        logic na = (dv >= h) || (a < dv);
        ep[i] = (out_en[i] && pa) ? pol_p : ~pol_p;
        en[i] = (out_en[NPH+i] && na) ? pol_n : ~pol_n;
      end
      if (t == h)
        for (int i = 0; i < NPH; i++) act_m[i] = dbuf_en ? stg_m[i] : int'(duty_b[i]);
      if (t == 0) begin
        for (int i = 0; i < NPH; i++) stg_m[i] = int'(duty_b[i]);
        if (tog_en) tog_m = ~tog_m;
      end
      k++;
    end
    @(negedge clk);
    chk({pwm_n, pwm_p} == {en, ep}, tag, int'({pwm_n, pwm_p}), int'({en, ep}));
    chk((~(pwm_p ^ {NPH{pol_p}}) & ~(pwm_n ^ {NPH{pol_n}})) == '0, "R7",
        int'({pwm_n, pwm_p}), 0);
    chk(tog_out == tog_m, "R12", int'(tog_out), int'(tog_m));
  endtask

  task automatic do_run(input int cycles, input string tag);
    run = 1'b0;
    step("R13 stopped");
    step("R13 stopped");
    run = 1'b1;
    for (int c = 0; c < cycles; c++) step(tag);
    run = 1'b0;
    step("R13 stopped");
  endtask

  initial begin
    for (int i = 0; i < NPH; i++) duty_b[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({pwm_n, pwm_p, tog_out} == 7'b0, "R1", int'({pwm_n, pwm_p, tog_out}), 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk({pwm_n, pwm_p, tog_out} == 7'b0, "R1", int'({pwm_n, pwm_p, tog_out}), 0);

    // R4 R5 R6: duty sweep 0..H+1 on every phase, H=6, d=2
    for (int j = 0; j < 8; j++) begin
      for (int i = 0; i < NPH; i++) duty_b[i] = CW'((j + i) % 8);
      do_run(26, "R4/R5/R6 sweep");
    end
    // R2 R3: other dead times, dt_en off, odd half-period
    dead_time = 8'd3;
    for (int j = 0; j < 7; j++) begin
      for (int i = 0; i < NPH; i++) duty_b[i] = CW'((j + 2*i) % 7);
      do_run(26, "R3 d=3");
    end
    dt_en = 1'b0; dead_time = 8'd5;
    for (int j = 0; j < 7; j++) begin
      for (int i = 0; i < NPH; i++) duty_b[i] = CW'((j + i) % 7);
      do_run(26, "R3 dt off");
    end
    dt_en = 1'b1; dead_time = 8'd1; half_period = 8'd5;
    for (int j = 0; j < 7; j++) begin
      for (int i = 0; i < NPH; i++) duty_b[i] = CW'((j + i) % 7);
      do_run(22, "R2 odd H");
    end
    half_period = 8'd6; dead_time = 8'd2;
    duty_b[0] = 8'd2; duty_b[1] = 8'd3; duty_b[2] = 8'd5;
    // R10: all polarity pairs
    for (int p = 0; p < 4; p++) begin
      pol_p = p[0]; pol_n = p[1];
      do_run(26, "R10 polarity");
    end
    pol_p = 1'b1; pol_n = 1'b1;
    // R11: per-pin enables
    out_en = 6'b101010; do_run(26, "R11 enable");
    out_en = 6'b010101; do_run(26, "R11 enable");
    out_en = 6'b111111;
    // R8: mid-period update, single buffer
    dbuf_en = 1'b0;
    run = 1'b0; step("R13 stopped"); step("R13 stopped");
    run = 1'b1;
    for (int c = 0; c < 3; c++) step("R8 update");
    duty_b[0] = 8'd4; duty_b[1] = 8'd1; duty_b[2] = 8'd0;
    for (int c = 0; c < 30; c++) step("R8 update");
    // R9: mid-period update, double buffer
    dbuf_en = 1'b1;
    run = 1'b0; step("R13 stopped"); step("R13 stopped");
    run = 1'b1;
    for (int c = 0; c < 8; c++) step("R9 dbuf");
    duty_b[0] = 8'd1; duty_b[1] = 8'd5; duty_b[2] = 8'd7;
    for (int c = 0; c < 40; c++) step("R9 dbuf");
    // R12: toggle disabled holds
    tog_en = 1'b0; dbuf_en = 1'b0;
    do_run(26, "R12 tog off");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule